// File: doc/BRIEF.md
# Multiplexed-Address Parallel Bus Master

This block performs single-byte read and write accesses to a peripheral on a shared 8-bit bus that carries both address and data. A request holds a 16-bit address, a direction flag, a target select (one of two chips) and a write byte. The master passes the address over the data lines in two strobed halves, low byte first. For a write it then drives the data byte; for a read it releases the lines. It pulls the chosen chip select low, then the read or write strobe. It waits for an active-low acknowledge, with a cycle-count timeout as a guard. Finally it parks the bus and reports the result through a one-cycle done pulse.

The data lines are presented as a split output/enable/input triple, so a pad or an on-chip tristate can be attached outside. The sequence is one enumerated state machine: `ST_IDLE` → `ST_ALO_SETUP` → `ST_ALO_STRB` → `ST_ALO_HOLD` → `ST_AHI_SETUP` → `ST_AHI_STRB` → `ST_AHI_HOLD` → `ST_DATA_SETUP` → `ST_SELECT` → `ST_STROBE` → `ST_FINISH` → `ST_IDLE`. Transitions: the idle state moves on when a request is accepted. Each strobe state moves on when its latch counter expires. `ST_STROBE` moves on when acknowledge is seen low or the timeout counter expires. Every other state lasts exactly one cycle.

Top module: `mux_bus_master`

## Requirements
- R1: While reset is asserted, and in the idle state, `bus_doe` is 0, `bus_cs0_n`, `bus_cs1_n`, `bus_rd_n` and `bus_wr_n` are 1, both latch strobes are 0, `done` is 0 and `req_ready` is 1. Reset is asynchronous and takes effect mid-access.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle until done has been given, `req_ready` is 0, and changes on the request inputs have no effect on the bus.
- R3: After acceptance, `bus_dout` carries `req_addr[7:0]` with `bus_doe`=1 for one setup cycle with `bus_adlo`=0. It then holds for LATCH_HOLD cycles with `bus_adlo`=1, and for one more cycle with `bus_adlo`=0.
- R4: The high address phase follows with the same shape, carrying `req_addr[15:8]` and strobing `bus_adhi`. The two latch strobes are never 1 together.
- R5: In the data setup cycle a write drives `req_wdata` with `bus_doe`=1 and keeps it through the done cycle. A read sets `bus_doe`=0 before any chip select or strobe goes low.
- R6: One cycle before the strobe, the chip select of the target goes low: `req_sel`=0 selects `bus_cs0_n`, `req_sel`=1 selects `bus_cs1_n`. The other stays high, and the select stays low through the strobe phase.
- R7: In the strobe phase `bus_rd_n` (read) or `bus_wr_n` (write) is 0. When `bus_ack_n` is sampled 0, the next cycle returns all four controls high with `done`=1 and `done_timeout`=0.
- R8: If `bus_ack_n` never reads 0, the strobe phase lasts exactly TMO_CYCLES cycles. Then `done`=1 with `done_timeout`=1.
- R9: `done_rdata` equals `bus_din` as sampled on the last strobe cycle for a read, and is 0 for a write.
- R10: `done` is a single-cycle pulse, and `req_ready` returns to 1 in the cycle after it.
- R11: If acknowledge is first seen in the very cycle in which the timeout expires, the access ends as acknowledged, with `done_timeout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | Target chip: 0 or 1 |
| req_addr | input | 2*DATA_W | Access address |
| req_wdata | input | DATA_W | Write byte |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DATA_W | Read byte (0 for writes) |
| done_timeout | output | 1 | Access ended on timeout |
| bus_dout | output | DATA_W | Value driven onto the data lines |
| bus_doe | output | 1 | Data line drive enable |
| bus_din | input | DATA_W | Value seen on the data lines |
| bus_adlo | output | 1 | Low address latch strobe, active high |
| bus_adhi | output | 1 | High address latch strobe, active high |
| bus_cs0_n | output | 1 | Chip select 0, active low |
| bus_cs1_n | output | 1 | Chip select 1, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ack_n | input | 1 | Acknowledge, active low |

## Verification
The outputs decode the registered state directly, so a wrong state or a wrong counter shows on the bus in that same cycle. It appears as a latch strobe that is too short or too long, an address half on the wrong phase, the data lines driven during a read, or a strobe that outlives the timeout. A wrong captured byte or flag shows only at the done pulse, one cycle after the wait ends. The bench therefore compares every bus line on every cycle of each access. It sweeps direction, target and acknowledge delay, including the cycle where acknowledge and timeout coincide.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ALO_SETUP,
        ST_ALO_STRB,
        ST_ALO_HOLD,
        ST_AHI_SETUP,
        ST_AHI_STRB,
        ST_AHI_HOLD,
        ST_DATA_SETUP,
        ST_SELECT,
        ST_STROBE,
        ST_FINISH
    } mbm_state_e;

endpackage

// File: rtl/mbm_counter.sv
// Phase counter: cleared while run is low, counts while run is high,
// raises last on the LIMIT-th consecutive run cycle.
module mbm_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    generate
        if (LIMIT <= 1) begin : g_single
            assign last = run;
        end else begin : g_count
            localparam int CW = $clog2(LIMIT);
            localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run) begin
                    cnt_q <= '0;
                end else if (cnt_q != TOP) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign last = run && (cnt_q == TOP);
        end
    endgenerate
endmodule

// File: rtl/mbm_capture.sv
// Result register: holds the read byte and the timeout flag of the last access.
module mbm_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              is_read,
    input  logic              timed_out,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              timeout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata   <= '0;
            timeout <= 1'b0;
        end else if (load) begin
            rdata   <= is_read ? din : '0;
            timeout <= timed_out;
        end
    end
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master #(
    parameter int DATA_W     = 8,
    parameter int LATCH_HOLD = 2,
    parameter int TMO_CYCLES = 200000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_sel,
    input  logic [2*DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                done,
    output logic [DATA_W-1:0]   done_rdata,
    output logic                done_timeout,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_doe,
    input  logic [DATA_W-1:0]   bus_din,
    output logic                bus_adlo,
    output logic                bus_adhi,
    output logic                bus_cs0_n,
    output logic                bus_cs1_n,
    output logic                bus_rd_n,
    output logic                bus_wr_n,
    input  logic                bus_ack_n
);
    import mbm_pkg::*;

    localparam int ADDR_W = 2 * DATA_W;

    mbm_state_e state_q, state_d;

    logic              wr_q;
    logic              sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    logic accept;
    logic latch_run, latch_last;
    logic wait_run, tmo_last;
    logic ack_seen, wait_end;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign latch_run = (state_q == ST_ALO_STRB) || (state_q == ST_AHI_STRB);
    assign wait_run  = (state_q == ST_STROBE);
    assign ack_seen  = !bus_ack_n;
    assign wait_end  = wait_run && (ack_seen || tmo_last);

    mbm_counter #(.LIMIT(LATCH_HOLD)) u_latch_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (latch_run),
        .last  (latch_last)
    );

    mbm_counter #(.LIMIT(TMO_CYCLES)) u_tmo_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wait_run),
        .last  (tmo_last)
    );

    mbm_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wait_end),
        .is_read   (!wr_q),
        .timed_out (!ack_seen),
        .din       (bus_din),
        .rdata     (done_rdata),
        .timeout   (done_timeout)
    );

    // Request register: loaded only on acceptance, so later input changes are ignored.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            sel_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            sel_q   <= req_sel;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = ST_ALO_SETUP;
            ST_ALO_SETUP:  state_d = ST_ALO_STRB;
            ST_ALO_STRB:   if (latch_last) state_d = ST_ALO_HOLD;
            ST_ALO_HOLD:   state_d = ST_AHI_SETUP;
            ST_AHI_SETUP:  state_d = ST_AHI_STRB;
            ST_AHI_STRB:   if (latch_last) state_d = ST_AHI_HOLD;
            ST_AHI_HOLD:   state_d = ST_DATA_SETUP;
            ST_DATA_SETUP: state_d = ST_SELECT;
            ST_SELECT:     state_d = ST_STROBE;
            ST_STROBE:     if (ack_seen || tmo_last) state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Output decode (Moore)
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        bus_doe   = 1'b0;
        bus_dout  = '0;
        bus_adlo  = 1'b0;
        bus_adhi  = 1'b0;
        bus_cs0_n = 1'b1;
        bus_cs1_n = 1'b1;
        bus_rd_n  = 1'b1;
        bus_wr_n  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_ALO_SETUP, ST_ALO_HOLD: begin
                bus_doe  = 1'b1;
                bus_dout = addr_q[DATA_W-1:0];
            end
            ST_ALO_STRB: begin
                bus_doe  = 1'b1;
                bus_dout = addr_q[DATA_W-1:0];
                bus_adlo = 1'b1;
            end
            ST_AHI_SETUP, ST_AHI_HOLD: begin
                bus_doe  = 1'b1;
                bus_dout = addr_q[ADDR_W-1:DATA_W];
            end
            ST_AHI_STRB: begin
                bus_doe  = 1'b1;
                bus_dout = addr_q[ADDR_W-1:DATA_W];
                bus_adhi = 1'b1;
            end
            ST_DATA_SETUP: begin
                bus_doe  = wr_q;
                bus_dout = wr_q ? wdata_q : '0;
            end
            ST_SELECT: begin
                bus_doe   = wr_q;
                bus_dout  = wr_q ? wdata_q : '0;
                bus_cs0_n = sel_q;
                bus_cs1_n = !sel_q;
            end
            ST_STROBE: begin
                bus_doe   = wr_q;
                bus_dout  = wr_q ? wdata_q : '0;
                bus_cs0_n = sel_q;
                bus_cs1_n = !sel_q;
                bus_rd_n  = wr_q;
                bus_wr_n  = !wr_q;
            end
            ST_FINISH: begin
                done     = 1'b1;
                bus_doe  = wr_q;
                bus_dout = wr_q ? wdata_q : '0;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
    parameter int DATA_W     = 8,
    parameter int LATCH_HOLD = 2,
    parameter int TMO_CYCLES = 200000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic [DATA_W-1:0] bus_dout,
    input logic              bus_doe,
    input logic              bus_adlo,
    input logic              bus_adhi,
    input logic              bus_cs0_n,
    input logic              bus_cs1_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n
);
    logic [15:0] hi_cnt;
    logic [31:0] stb_cnt;
    logic        strobing;

    assign strobing = !bus_rd_n || !bus_wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            stb_cnt <= '0;
        end else begin
            hi_cnt  <= (bus_adlo || bus_adhi) ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
            stb_cnt <= strobing ? stb_cnt + 1'b1 : '0;
        end
    end

    a_r1_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs0_n && bus_cs1_n && bus_rd_n && bus_wr_n && !bus_doe && !bus_adlo && !bus_adhi));

    a_r3_setup_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_adlo) || $rose(bus_adhi)) |-> ($stable(bus_dout) && $past(bus_doe)));

    a_r3_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_adlo) || $fell(bus_adhi)) |-> ($stable(bus_dout) && bus_doe));

    a_r3_latch_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_adlo) || $fell(bus_adhi)) |-> (hi_cnt >= 16'(LATCH_HOLD)));

    a_r4_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_adlo && bus_adhi));

    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_doe);

    a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_cs0_n && !bus_cs1_n));

    a_r6_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        strobing |-> (bus_cs0_n != bus_cs1_n));

    a_r8_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
        strobing |-> (stb_cnt < 32'(TMO_CYCLES)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!req_ready && bus_rd_n && bus_wr_n && bus_cs0_n && bus_cs1_n));
endmodule

bind mux_bus_master mbm_checker #(
    .DATA_W     (DATA_W),
    .LATCH_HOLD (LATCH_HOLD),
    .TMO_CYCLES (TMO_CYCLES)
) u_mbm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .bus_adlo  (bus_adlo),
    .bus_adhi  (bus_adhi),
    .bus_cs0_n (bus_cs0_n),
    .bus_cs1_n (bus_cs1_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n)
);

// File: tb/mux_bus_master_tb_top.sv
`timescale 1ns/1ps
module mux_bus_master_tb_top;
    localparam int DW = 8;
    localparam int H  = 2;
    localparam int T  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_sel = 1'b0;
    logic [2*DW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          done;
    logic [DW-1:0] done_rdata;
    logic          done_timeout;
    logic [DW-1:0] bus_dout;
    logic          bus_doe;
    logic [DW-1:0] bus_din = '0;
    logic          bus_adlo, bus_adhi, bus_cs0_n, bus_cs1_n, bus_rd_n, bus_wr_n;
    logic          bus_ack_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mux_bus_master #(.DATA_W(DW), .LATCH_HOLD(H), .TMO_CYCLES(T)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_sel(req_sel), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .done_rdata(done_rdata), .done_timeout(done_timeout),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_adlo(bus_adlo), .bus_adhi(bus_adhi), .bus_cs0_n(bus_cs0_n),
        .bus_cs1_n(bus_cs1_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_ack_n(bus_ack_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Observed bus word: {doe, adlo, adhi, cs0_n, cs1_n, rd_n, wr_n, ready, done, dout-if-driven}
    function automatic logic [31:0] pack(input logic doe, input logic alo, input logic ahi,
                                         input logic c0, input logic c1, input logic rd,
                                         input logic wr, input logic rdy, input logic dn,
                                         input logic [DW-1:0] d);
        return {15'd0, doe, alo, ahi, c0, c1, rd, wr, rdy, dn, (doe ? d : 8'h00)};
    endfunction

    function automatic logic [31:0] observed();
        return pack(bus_doe, bus_adlo, bus_adhi, bus_cs0_n, bus_cs1_n, bus_rd_n,
                    bus_wr_n, req_ready, done, bus_dout);
    endfunction

    task automatic idle_check(input string tag);
        chk(tag, observed(), pack(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00));
    endtask

    // One access; ack_at = strobe cycle index where ack goes low (>= T: never).
    task automatic access(input logic wr, input logic sel, input logic [15:0] addr,
                          input logic [7:0] wd, input int ack_at);
        int base, n, fin;
        logic [7:0] rdv;
        logic tmo;
        base = 2*H + 6;
        n    = (ack_at < T) ? ack_at + 1 : T;
        tmo  = (ack_at >= T);
        fin  = base + n;
        rdv  = addr[7:0] ^ 8'h5A;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_sel = sel; req_addr = addr; req_wdata = wd;
        bus_din = rdv; bus_ack_n = 1'b1;
        @(posedge clk);
        for (int j = 0; j <= fin + 1; j++) begin
            logic [31:0] e;
            string tg;
            @(negedge clk);
            if (j == 1) begin
                req_addr = ~addr; req_wdata = ~wd; req_write = ~wr; req_sel = ~sel;
            end
            if (j == 0) begin
                e = pack(1, 0, 0, 1, 1, 1, 1, 0, 0, addr[7:0]); tg = "R3 low setup / R2";
            end else if (j <= H) begin
                e = pack(1, 1, 0, 1, 1, 1, 1, 0, 0, addr[7:0]); tg = "R3 low strobe";
            end else if (j == H + 1) begin
                e = pack(1, 0, 0, 1, 1, 1, 1, 0, 0, addr[7:0]); tg = "R3 low hold";
            end else if (j == H + 2) begin
                e = pack(1, 0, 0, 1, 1, 1, 1, 0, 0, addr[15:8]); tg = "R4 high setup";
            end else if (j <= 2*H + 2) begin
                e = pack(1, 0, 1, 1, 1, 1, 1, 0, 0, addr[15:8]); tg = "R4 high strobe";
            end else if (j == 2*H + 3) begin
                e = pack(1, 0, 0, 1, 1, 1, 1, 0, 0, addr[15:8]); tg = "R4 high hold";
            end else if (j == 2*H + 4) begin
                e = pack(wr, 0, 0, 1, 1, 1, 1, 0, 0, wd); tg = "R5 data setup";
            end else if (j == 2*H + 5) begin
                e = pack(wr, 0, 0, sel, !sel, 1, 1, 0, 0, wd); tg = "R6 select";
            end else if (j < fin) begin
                e = pack(wr, 0, 0, sel, !sel, wr, !wr, 0, 0, wd); tg = tmo ? "R8 strobe wait" : "R7 strobe wait";
            end else if (j == fin) begin
                e = pack(wr, 0, 0, 1, 1, 1, 1, 0, 1, wd); tg = "R7 done cycle";
            end else begin
                e = pack(0, 0, 0, 1, 1, 1, 1, 1, 0, 8'h00); tg = "R10 back to idle";
            end
            chk(tg, observed(), e);
            if (j == fin) begin
                chk("R9 read data", {24'd0, done_rdata}, {24'd0, (wr ? 8'h00 : rdv)});
                chk((ack_at == T-1) ? "R11 ack wins at expiry" : "R8 timeout flag",
                    {31'd0, done_timeout}, {31'd0, tmo});
                req_valid = 1'b0;
                bus_ack_n = 1'b1;
            end
            if (j >= base && j < fin) begin
                bus_ack_n = ((j - base) >= ack_at) ? 1'b0 : 1'b1;
            end
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired (R10 no completion)");
        summary();
        $finish;
    end

    initial begin
        int delays [5];
        delays = '{0, 1, 3, T-1, T};
        repeat (3) @(negedge clk);
        idle_check("R1 in reset");
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            idle_check("R2 idle without request");
        end
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 2; s++)
                for (int d = 0; d < 5; d++) begin
                    logic [15:0] a;
                    a = 16'hA5C3 ^ 16'((w*10 + s*5 + d) * 16'h1357);
                    access(w[0], s[0], a, a[15:8] ^ 8'h3C, delays[d]);
                end
        // Reset in the middle of an access
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sel = 1'b1; req_addr = 16'h1234;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2*H + 6) @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        idle_check("R1 reset mid-access");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 idle after reset");
        access(1'b0, 1'b0, 16'hFF00, 8'h00, 2);
        summary();
        $finish;
    end
endmodule